// File: doc/BRIEF.md
# Channel status word generator

This block builds the 192-bit channel status block that an audio interface transmitter carries one bit per frame in the C slot. The frame encoder gives one strobe per frame. On each strobe the block samples the serial channel status input, works out the status bit for the current position in the block, and presents it on a registered output together with a marker for the first bit of the block. The position counter runs from 0 to 191 and then wraps.

The static control pins are read according to the mode. With the professional select low, the pins set fixed professional fields: the pro/consumer flag, four single-bit flags, and a three-bit emphasis field. The block also computes a CRC-8 over the first 23 bytes and sends it as the last byte. With the select high, the same pins set consumer fields, and a two-bit frequency field is written into bits 24 and 25. A frequency code of 11 selects CD mode. In that mode the serial input carries the subcode frame clock, so it no longer supplies status bits. A transparent control passes the serial stream through untouched.

Bit n of the block is emitted at frame n. Byte k holds bits 8k to 8k+7, least significant bit first.

Top module: `cs_word_gen`

## Requirements
- R1: Each cycle with `frame_stb_i` high emits exactly one block bit, at positions 0,1,…,191 and then back to 0. `cs_bit_o` and `blk_first_o` change only on a clock edge where the strobe is high, and hold otherwise. `blk_first_o` is 1 exactly while the bit shown is position 0.
- R2: While `rst_ni` is low, `cs_bit_o` and `blk_first_o` are 0. The first bit emitted after reset is position 0.
- R3: The mode is decoded as follows, in priority order. `xpar_i`=1 selects transparent. Otherwise `pro_ni`=0 selects professional. Otherwise `fc_i`=2'b11 selects CD. Otherwise the mode is consumer. `cd_mode_o` is 1 exactly in CD mode and follows the inputs combinationally.
- R4: In transparent mode every emitted bit equals `cs_ser_i` sampled with its strobe. `pro_ni`, `ovr_ni`, `emph_i` and `fc_i` have no effect, and no CRC is inserted.
- R5: In professional mode, bit 0 is 1. Bits 1, 6, 7 and 9 are the inverse of `ovr_ni[0]`, `ovr_ni[1]`, `ovr_ni[2]` and `ovr_ni[3]`. `ovr_ni[4]` has no effect.
- R6: In professional mode, bits 2, 3 and 4 come from `emph_i`. Code 00 gives all three 0. Code 01 sets only bit 2. Code 10 sets bits 2 and 3. Code 11 sets bits 2, 3 and 4.
- R7: In professional mode, bits 184..191 carry a CRC. The register starts at 8'hFF. It takes each emitted bit 0..183 in order: fb = r[7]^bit, then r = {r[6:0],0} ^ (fb ? 8'h1D : 0). Bit 184+j is r[7-j] of the final register. `fc_i` has no effect in this mode.
- R8: In consumer and CD modes, bit 0 is 0. Bits 2, 3, 8, 9 and 15 are the inverse of `ovr_ni[0]` through `ovr_ni[4]`. `emph_i` has no effect, and bits 184..191 are not replaced by a CRC.
- R9: In consumer mode, bit 24 is `fc_i[0]` and bit 25 is `fc_i[1]`. In CD mode both bits are 0.
- R10: In CD mode, every bit not fixed by R8 or R9 is 0, whatever `cs_ser_i` carries.
- R11: In professional and consumer modes, every bit not fixed by R5–R9 equals `cs_ser_i` sampled with its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One pulse per frame; advances the block position |
| cs_ser_i | input | 1 | Serial channel status bit for the current frame |
| pro_ni | input | 1 | Low selects professional, high selects consumer |
| xpar_i | input | 1 | Transparent pass-through |
| ovr_ni | input | 5 | Inverted dedicated status bits, meaning set by mode |
| emph_i | input | 2 | Professional emphasis code |
| fc_i | input | 2 | Consumer frequency code; 11 selects CD mode |
| cs_bit_o | output | 1 | Channel status bit for the last strobed frame |
| blk_first_o | output | 1 | High while `cs_bit_o` is block position 0 |
| cd_mode_o | output | 1 | CD mode decoded |

## Verification
`cs_bit_o` and `blk_first_o` come from one register, so each is due on the edge that samples the strobe. The bench raises the strobe on a falling edge, drops it on the next falling edge and compares the outputs at that point, half a cycle after the updating edge. At chosen positions it waits an extra strobe-free cycle and checks that both outputs hold. `cd_mode_o` has no register. It is checked on the falling edge right after the control inputs change, before any strobe. Every bit of each full 192-bit block is compared against a word the bench builds on its own, with its own CRC, for every emphasis code, every frequency code and the transparent mode.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    MODE_PRO  = 2'd0,
    MODE_CON  = 2'd1,
    MODE_CD   = 2'd2,
    MODE_XPAR = 2'd3
  } cs_mode_e;

  localparam int unsigned CRC_W = 8;
  localparam int unsigned OVR_W = 5;
endpackage

// File: rtl/cs_mode_dec.sv
module cs_mode_dec
  import cs_pkg::*;
(
  input  logic       pro_ni,
  input  logic       xpar_i,
  input  logic [1:0] fc_i,
  output cs_mode_e   mode_o
);
  always_comb begin
    if (xpar_i)       mode_o = MODE_XPAR;
    else if (!pro_ni) mode_o = MODE_PRO;
    else if (&fc_i)   mode_o = MODE_CD;
    else              mode_o = MODE_CON;
  end
endmodule

// File: rtl/cs_frame_ctr.sv
module cs_frame_ctr
  import cs_pkg::*;
#(
  parameter int unsigned BLOCK_BITS = 192,
  parameter int unsigned IW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o,
  output logic          first_o,
  output logic          crc_win_o
);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (adv_i)  idx_q <= (int'(idx_q) == BLOCK_BITS - 1) ? '0 : idx_q + 1'b1;
  end

  assign idx_o     = idx_q;
  assign first_o   = (idx_q == '0);
  assign crc_win_o = int'(idx_q) < BLOCK_BITS - CRC_W;

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < BLOCK_BITS); // R1
  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && int'(idx_q) == BLOCK_BITS - 1 |=> idx_q == '0); // R1
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q)); // R1
endmodule

// File: rtl/cs_crc.sv
module cs_crc
  import cs_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 8'h1D,
  parameter logic [CRC_W-1:0] INIT = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             restart_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, seed, nxt;
  logic             fb;

  always_comb begin
    seed = restart_i ? INIT : crc_q;
    fb   = seed[CRC_W-1] ^ bit_i;
    nxt  = {seed[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (upd_i)  crc_q <= nxt;
  end

  assign crc_o = crc_q;

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(crc_q)); // R7
endmodule

// File: rtl/cs_bit_sel.sv
module cs_bit_sel
  import cs_pkg::*;
#(
  parameter int unsigned BLOCK_BITS = 192,
  parameter int unsigned IW         = 8
) (
  input  cs_mode_e         mode_i,
  input  logic [IW-1:0]    idx_i,
  input  logic             ser_i,
  input  logic [OVR_W-1:0] ovr_ni,
  input  logic [1:0]       emph_i,
  input  logic [1:0]       fc_i,
  input  logic [CRC_W-1:0] crc_i,
  output logic             bit_o
);
  localparam int unsigned CRC_BASE = BLOCK_BITS - CRC_W;

  int unsigned pos;
  logic [2:0]  emph_f;   // {bit4, bit3, bit2}
  logic [1:0]  fc_f;
  logic [2:0]  crc_off;
  logic        src;

  always_comb begin
    pos = int'(idx_i);
    unique case (emph_i)
      2'b00:   emph_f = 3'b000;
      2'b01:   emph_f = 3'b001;
      2'b10:   emph_f = 3'b011;
      default: emph_f = 3'b111;
    endcase
    fc_f    = (&fc_i) ? 2'b00 : fc_i;
    crc_off = 3'(pos - CRC_BASE);
    src     = (mode_i == MODE_CD) ? 1'b0 : ser_i;
    bit_o   = src;
    unique case (mode_i)
      MODE_XPAR: bit_o = ser_i;
      MODE_PRO: begin
        if (pos >= CRC_BASE) bit_o = crc_i[3'd7 - crc_off];
        else begin
          case (pos)
            0:       bit_o = 1'b1;
            1:       bit_o = ~ovr_ni[0];
            2:       bit_o = emph_f[0];
            3:       bit_o = emph_f[1];
            4:       bit_o = emph_f[2];
            6:       bit_o = ~ovr_ni[1];
            7:       bit_o = ~ovr_ni[2];
            9:       bit_o = ~ovr_ni[3];
            default: bit_o = src;
          endcase
        end
      end
      default: begin
        case (pos)
          0:       bit_o = 1'b0;
          2:       bit_o = ~ovr_ni[0];
          3:       bit_o = ~ovr_ni[1];
          8:       bit_o = ~ovr_ni[2];
          9:       bit_o = ~ovr_ni[3];
          15:      bit_o = ~ovr_ni[4];
          24:      bit_o = fc_f[0];
          25:      bit_o = fc_f[1];
          default: bit_o = src;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/cs_word_gen.sv
module cs_word_gen
  import cs_pkg::*;
#(
  parameter int unsigned      BLOCK_BITS = 192,  // multiple of 8, at least 32
  parameter logic [CRC_W-1:0] CRC_POLY   = 8'h1D,
  parameter logic [CRC_W-1:0] CRC_INIT   = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_stb_i,
  input  logic             cs_ser_i,
  input  logic             pro_ni,
  input  logic             xpar_i,
  input  logic [OVR_W-1:0] ovr_ni,
  input  logic [1:0]       emph_i,
  input  logic [1:0]       fc_i,
  output logic             cs_bit_o,
  output logic             blk_first_o,
  output logic             cd_mode_o
);
  localparam int unsigned IW = $clog2(BLOCK_BITS);

  cs_mode_e         mode;
  logic [IW-1:0]    idx;
  logic             first, crc_win, nxt_bit;
  logic [CRC_W-1:0] crc;
  logic             bit_q, first_q;

  cs_mode_dec u_mode (
    .pro_ni (pro_ni),
    .xpar_i (xpar_i),
    .fc_i   (fc_i),
    .mode_o (mode)
  );

  cs_frame_ctr #(.BLOCK_BITS(BLOCK_BITS), .IW(IW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (frame_stb_i),
    .idx_o     (idx),
    .first_o   (first),
    .crc_win_o (crc_win)
  );

  cs_bit_sel #(.BLOCK_BITS(BLOCK_BITS), .IW(IW)) u_sel (
    .mode_i (mode),
    .idx_i  (idx),
    .ser_i  (cs_ser_i),
    .ovr_ni (ovr_ni),
    .emph_i (emph_i),
    .fc_i   (fc_i),
    .crc_i  (crc),
    .bit_o  (nxt_bit)
  );

  cs_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (frame_stb_i && crc_win),
    .restart_i (first),
    .bit_i     (nxt_bit),
    .crc_o     (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= 1'b0;
      first_q <= 1'b0;
    end else if (frame_stb_i) begin
      bit_q   <= nxt_bit;
      first_q <= first;
    end
  end

  assign cs_bit_o    = bit_q;
  assign blk_first_o = first_q;
  assign cd_mode_o   = (mode == MODE_CD);

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_i |=> $stable(cs_bit_o) && $stable(blk_first_o)); // R1
  AST_XPAR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i && xpar_i |=> cs_bit_o == $past(cs_ser_i)); // R4
  AST_PRO_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i && first && !xpar_i && !pro_ni |=> cs_bit_o && blk_first_o); // R5
  AST_CON_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i && first && !xpar_i && pro_ni |=> !cs_bit_o && blk_first_o); // R8
  AST_CD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_mode_o |-> pro_ni && !xpar_i && (&fc_i)); // R3
endmodule

// File: tb/tb_cs_word_gen.sv
module tb_cs_word_gen;
  localparam int NB   = 192;
  localparam int CB   = NB - 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_stb_i = 1'b0, cs_ser_i = 1'b0;
  logic       pro_ni = 1'b0, xpar_i = 1'b0;
  logic [4:0] ovr_ni = '1;
  logic [1:0] emph_i = '0, fc_i = '0;
  logic       cs_bit_o, blk_first_o, cd_mode_o;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  logic ser_pat [NB];
  logic exp_w   [NB];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk_i = ~clk_i;

  cs_word_gen dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_stb_i(frame_stb_i), .cs_ser_i(cs_ser_i),
    .pro_ni(pro_ni), .xpar_i(xpar_i), .ovr_ni(ovr_ni), .emph_i(emph_i), .fc_i(fc_i),
    .cs_bit_o(cs_bit_o), .blk_first_o(blk_first_o), .cd_mode_o(cd_mode_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int n);
    if (xpar_i) return "R4";
    if (!pro_ni) begin
      if (n == 0 || n == 1 || n == 6 || n == 7 || n == 9) return "R5";
      if (n >= 2 && n <= 4) return "R6";
      if (n >= CB) return "R7";
      return "R11";
    end
    if (n == 0 || n == 2 || n == 3 || n == 8 || n == 9 || n == 15) return "R8";
    if (n == 24 || n == 25) return "R9";
    return (&fc_i) ? "R10" : "R11";
  endfunction

  function automatic logic ref_bit(input int n);
    logic cd = pro_ni && (&fc_i);
    logic s  = cd ? 1'b0 : ser_pat[n];
    if (xpar_i) return ser_pat[n];
    if (!pro_ni) begin
      case (n)
        0: return 1'b1;
        1: return ~ovr_ni[0];
        2: return emph_i != 2'b00;
        3: return emph_i[1];
        4: return emph_i == 2'b11;
        6: return ~ovr_ni[1];
        7: return ~ovr_ni[2];
        9: return ~ovr_ni[3];
        default: return s;
      endcase
    end
    case (n)
      0:  return 1'b0;
      2:  return ~ovr_ni[0];
      3:  return ~ovr_ni[1];
      8:  return ~ovr_ni[2];
      9:  return ~ovr_ni[3];
      15: return ~ovr_ni[4];
      24: return cd ? 1'b0 : fc_i[0];
      25: return cd ? 1'b0 : fc_i[1];
      default: return s;
    endcase
  endfunction

  task automatic build_exp();
    logic [7:0] c = 8'hFF;
    for (int n = 0; n < NB; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ser_pat[n] = lfsr[0];
    end
    for (int n = 0; n < NB; n++) exp_w[n] = ref_bit(n);
    for (int n = 0; n < CB; n++) begin
      logic fb = c[7] ^ exp_w[n];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
    end
    if (!xpar_i && !pro_ni)
      for (int j = 0; j < 8; j++) exp_w[CB + j] = c[7 - j];
  endtask

  task automatic run_block(input logic p_n, input logic xp, input logic [4:0] ov,
                           input logic [1:0] em, input logic [1:0] fc);
    @(negedge clk_i);
    pro_ni = p_n; xpar_i = xp; ovr_ni = ov; emph_i = em; fc_i = fc;
    #1;
    chk("R3", "cd_mode_o", int'(cd_mode_o), int'(!xp && p_n && (&fc)));
    build_exp();
    for (int n = 0; n < NB; n++) begin
      @(negedge clk_i);
      cs_ser_i = ser_pat[n];
      frame_stb_i = 1'b1;
      @(negedge clk_i);
      frame_stb_i = 1'b0;
      cs_ser_i = ~cs_ser_i;
      chk(tag_of(n), $sformatf("bit %0d", n), int'(cs_bit_o), int'(exp_w[n]));
      chk("R1", $sformatf("first flag at %0d", n), int'(blk_first_o), int'(n == 0));
      if (n % 37 == 5) begin
        @(negedge clk_i);
        chk("R1", "hold without strobe", int'(cs_bit_o), int'(exp_w[n]));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R2", "cs_bit_o in reset", int'(cs_bit_o), 0);
    chk("R2", "blk_first_o in reset", int'(blk_first_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2", "cs_bit_o after reset", int'(cs_bit_o), 0);
    // R4: transparent with both selects
    run_block(1'b0, 1'b1, 5'h0A, 2'b11, 2'b11);
    run_block(1'b1, 1'b1, 5'h15, 2'b01, 2'b11);
    // R5 R6 R7: professional, every emphasis code
    for (int i = 0; i < 4; i++)
      run_block(1'b0, 1'b0, 5'(i * 7 + 3), 2'(i), 2'(3 - i));
    run_block(1'b0, 1'b0, 5'h00, 2'b10, 2'b11);
    run_block(1'b0, 1'b0, 5'h1F, 2'b01, 2'b00);
    // R8 R9 R10 R11: consumer, every frequency code (11 = CD)
    for (int i = 0; i < 4; i++)
      run_block(1'b1, 1'b0, 5'(i * 11 + 5), 2'(3 - i), 2'(i));
    run_block(1'b1, 1'b0, 5'h00, 2'b11, 2'b11);
    run_block(1'b1, 1'b0, 5'h1F, 2'b00, 2'b01);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule